// File: doc/BRIEF.md
# DMA Channel Trigger Selector

This block stands in front of a four-channel DMA engine and decides, for each channel, when a transfer request is raised. Every channel owns a 4-bit source code that picks one cause out of a fixed set: a write-one software strobe, a rising or falling edge on the channel's own pin, a rising edge on one of two port inputs, an 8-bit timer underflow, compare A or compare B events of two 16-bit timers, serial receive-full or transmit-empty, and A/D conversion done.

When the chosen cause fires, a sticky pending bit is set. That bit drives the request to the engine. It drops when the engine reports that the transfer has begun. Software can also drop it by writing one to it. Asynchronous pins and port inputs pass through a two-stage synchronizer and an edge detector first. The on-chip event inputs are single-cycle strobes that are used as they arrive.

Software reaches the block through a byte-wide bus with combinational read data. Address 0 holds the codes for channels 0 and 1, and address 1 holds those for channels 2 and 3. Address 2 is the software strobe register. Address 3 holds the pending bits.

Top module: `dtsel_top`

## Requirements
- R1: After reset every source code is 0000, every pending bit is 0, and `dma_req_o` is 0.
- R2: A write to address 0 sets channel 0's code from bits [3:0] and channel 1's code from bits [7:4]. Address 1 does the same for channels 2 and 3. Reading either address returns the stored codes in the same bit positions.
- R3: A write to address 2 with bit c set raises channel c's pending bit at that same clock edge, provided channel c's code is 0000. Zero bits in the write do nothing, and reading address 2 returns 0.
- R4: A software strobe to a channel whose code is not 0000 leaves that channel's pending bit unchanged.
- R5: Code 0101 selects the timer-8 underflow. Code 0110 selects compare B of timer A and 0111 selects compare A of timer A. Code 1000 selects compare B of timer B and 1001 selects compare A of timer B. Code 1010 selects receive-full, 1011 selects transmit-empty, and 1100 selects A/D done. A strobe on the selected input sets the pending bit at the clock edge where the strobe is high.
- R6: Code 0001 reacts to a falling edge on the channel's pin and code 0010 to a rising edge. Code 0011 reacts to a rising edge on port A and 0100 to a rising edge on port B. The pending bit is set at the third rising clock edge after the input changes, and not before.
- R7: Codes 1101, 1110 and 1111 never set the pending bit, whatever the inputs do.
- R8: `dma_req_o[c]` equals channel c's pending bit. A high `xfer_start_i[c]` clears the bit at that clock edge.
- R9: Reading address 3 returns the pending bits in bits [3:0], with bit c for channel c. Writing 1 to bit c clears that pending bit, and writing 0 leaves it as it is.
- R10: If a selected event and a clear (a write to address 3 or a transfer start) fall on the same edge, the pending bit ends up set.
- R11: A strobe on an input that the channel's code does not select leaves the pending bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| pin_i | input | 4 | Per-channel edge pin, asynchronous |
| port_a_i | input | 4 | Per-channel port input A, asynchronous |
| port_b_i | input | 4 | Per-channel port input B, asynchronous |
| tmr8_uf_i | input | 4 | Timer-8 underflow strobe per channel |
| t16a_cmpb_i | input | 4 | Timer A compare B strobe per channel |
| t16a_cmpa_i | input | 4 | Timer A compare A strobe per channel |
| t16b_cmpb_i | input | 4 | Timer B compare B strobe per channel |
| t16b_cmpa_i | input | 4 | Timer B compare A strobe per channel |
| rx_full_i | input | 4 | Serial receive-full strobe per channel |
| tx_empty_i | input | 4 | Serial transmit-empty strobe per channel |
| adc_done_i | input | 4 | A/D conversion done strobe per channel |
| xfer_start_i | input | 4 | Transfer-begun pulse from the DMA engine per channel |
| dma_req_o | output | 4 | Request to the DMA engine per channel |

## Verification
A selected trigger event can land on the same edge as a clear of the pending bit, where the clear comes either from a one-write to address 3 or from a transfer-start pulse. The bench provokes both pairings by raising the timer-8 strobe in the same cycle as the clear write, and again in the same cycle as `xfer_start_i`. It then requires that the request is still high afterwards. Control cases with the clear alone must show the request falling, so the bench can tell a lost request apart from a clear that never took effect.

// File: rtl/dtsel_pkg.sv
package dtsel_pkg;
    localparam int unsigned CODE_W = 4;

    localparam logic [CODE_W-1:0] SRC_SOFT      = 4'd0;
    localparam logic [CODE_W-1:0] SRC_PIN_FALL  = 4'd1;
    localparam logic [CODE_W-1:0] SRC_PIN_RISE  = 4'd2;
    localparam logic [CODE_W-1:0] SRC_PORT_A    = 4'd3;
    localparam logic [CODE_W-1:0] SRC_PORT_B    = 4'd4;
    localparam logic [CODE_W-1:0] SRC_TMR8_UF   = 4'd5;
    localparam logic [CODE_W-1:0] SRC_T16A_CMPB = 4'd6;
    localparam logic [CODE_W-1:0] SRC_T16A_CMPA = 4'd7;
    localparam logic [CODE_W-1:0] SRC_T16B_CMPB = 4'd8;
    localparam logic [CODE_W-1:0] SRC_T16B_CMPA = 4'd9;
    localparam logic [CODE_W-1:0] SRC_RX_FULL   = 4'd10;
    localparam logic [CODE_W-1:0] SRC_TX_EMPTY  = 4'd11;
    localparam logic [CODE_W-1:0] SRC_ADC_DONE  = 4'd12;
    localparam logic [CODE_W-1:0] SRC_LAST      = SRC_ADC_DONE;

    // one channel's hardware event strobes, all single-cycle and synchronous
    typedef struct packed {
        logic pin_fall;
        logic pin_rise;
        logic port_a;
        logic port_b;
        logic tmr8_uf;
        logic t16a_cmpb;
        logic t16a_cmpa;
        logic t16b_cmpb;
        logic t16b_cmpa;
        logic rx_full;
        logic tx_empty;
        logic adc_done;
    } chan_ev_t;
endpackage

// File: rtl/dtsel_sync.sv
module dtsel_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic [W-1:0]             prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.prev    = st_q.pipe[LAST];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = st_q.pipe[LAST] & ~st_q.prev;
    assign fall_o = ~st_q.pipe[LAST] & st_q.prev;

    // R6: an edge event lasts exactly one cycle
    a_r6_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
    a_r6_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/dtsel_regs.sv
module dtsel_regs
    import dtsel_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned AW  = 2
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [AW-1:0]                addr_i,
    input  logic [7:0]                   wdata_i,
    input  logic                         wr_i,
    output logic [7:0]                   rdata_o,
    input  logic [NCH-1:0]               pend_i,
    output logic [NCH-1:0][CODE_W-1:0]   sel_o,
    output logic [NCH-1:0]               sw_trig_o,
    output logic [NCH-1:0]               clr_o
);
    localparam int unsigned NSELREG   = (NCH + 1) / 2;
    localparam logic [AW-1:0] ADDR_SW   = AW'(NSELREG);
    localparam logic [AW-1:0] ADDR_PEND = AW'(NSELREG + 1);

    typedef struct packed {
        logic [NCH-1:0][CODE_W-1:0] sel;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        sw_trig_o = '0;
        clr_o     = '0;
        rdata_o   = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr_i == AW'(c / 2)) begin
                if (wr_i) begin
                    st_d.sel[c] = (c % 2 == 1) ? wdata_i[7:4] : wdata_i[3:0];
                end
                rdata_o[4*(c%2) +: 4] = st_q.sel[c];
            end
        end
        if (wr_i && addr_i == ADDR_SW)   sw_trig_o = wdata_i[NCH-1:0];
        if (wr_i && addr_i == ADDR_PEND) clr_o     = wdata_i[NCH-1:0];
        if (addr_i == ADDR_PEND)         rdata_o[NCH-1:0] = pend_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sel_o = st_q.sel;

    // R2: source codes only move on a bus write
    a_r2_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(sel_o));
endmodule

// File: rtl/dtsel_chan.sv
module dtsel_chan
    import dtsel_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] sel_i,
    input  chan_ev_t          ev_i,
    input  logic              sw_trig_i,
    input  logic              clr_i,
    input  logic              start_i,
    output logic              pend_o
);
    typedef struct packed {
        logic pend;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        unique case (sel_i)
            SRC_SOFT:      hit = sw_trig_i;
            SRC_PIN_FALL:  hit = ev_i.pin_fall;
            SRC_PIN_RISE:  hit = ev_i.pin_rise;
            SRC_PORT_A:    hit = ev_i.port_a;
            SRC_PORT_B:    hit = ev_i.port_b;
            SRC_TMR8_UF:   hit = ev_i.tmr8_uf;
            SRC_T16A_CMPB: hit = ev_i.t16a_cmpb;
            SRC_T16A_CMPA: hit = ev_i.t16a_cmpa;
            SRC_T16B_CMPB: hit = ev_i.t16b_cmpb;
            SRC_T16B_CMPA: hit = ev_i.t16b_cmpa;
            SRC_RX_FULL:   hit = ev_i.rx_full;
            SRC_TX_EMPTY:  hit = ev_i.tx_empty;
            SRC_ADC_DONE:  hit = ev_i.adc_done;
            default:       hit = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (hit)                  st_d.pend = 1'b1;
        else if (clr_i || start_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R10: a selected event always leaves the request set
    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |=> pend_o);
    // R8: transfer start without a new event drops the request
    a_r8_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !hit) |=> !pend_o);
    // R9: software clear without a new event drops the request
    a_r9_clr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !hit) |=> !pend_o);
    // R7: reserved codes never raise the request
    a_r7_reserved_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i > SRC_LAST && !pend_o) |=> !pend_o);
    // R4: a software strobe alone cannot raise a hardware-sourced channel
    a_r4_sw_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i != SRC_SOFT && ev_i == '0 && !pend_o) |=> !pend_o);
endmodule

// File: rtl/dtsel_top.sv
module dtsel_top
    import dtsel_pkg::*;
#(
    parameter int unsigned NCH         = 4,
    parameter int unsigned AW          = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic [7:0]      bus_wdata_i,
    input  logic            bus_wr_i,
    output logic [7:0]      bus_rdata_o,
    input  logic [NCH-1:0]  pin_i,
    input  logic [NCH-1:0]  port_a_i,
    input  logic [NCH-1:0]  port_b_i,
    input  logic [NCH-1:0]  tmr8_uf_i,
    input  logic [NCH-1:0]  t16a_cmpb_i,
    input  logic [NCH-1:0]  t16a_cmpa_i,
    input  logic [NCH-1:0]  t16b_cmpb_i,
    input  logic [NCH-1:0]  t16b_cmpa_i,
    input  logic [NCH-1:0]  rx_full_i,
    input  logic [NCH-1:0]  tx_empty_i,
    input  logic [NCH-1:0]  adc_done_i,
    input  logic [NCH-1:0]  xfer_start_i,
    output logic [NCH-1:0]  dma_req_o
);
    localparam int unsigned NASYNC = 3 * NCH;

    logic [NASYNC-1:0]          async_rise, async_fall;
    logic [NCH-1:0][CODE_W-1:0] sel;
    logic [NCH-1:0]             sw_trig, clr, pend;

    dtsel_sync #(
        .W      (NASYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({port_b_i, port_a_i, pin_i}),
        .rise_o  (async_rise),
        .fall_o  (async_fall)
    );

    dtsel_regs #(
        .NCH (NCH),
        .AW  (AW)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .wr_i      (bus_wr_i),
        .rdata_o   (bus_rdata_o),
        .pend_i    (pend),
        .sel_o     (sel),
        .sw_trig_o (sw_trig),
        .clr_o     (clr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        chan_ev_t ev;
        always_comb begin
            ev.pin_fall  = async_fall[c];
            ev.pin_rise  = async_rise[c];
            ev.port_a    = async_rise[NCH + c];
            ev.port_b    = async_rise[2*NCH + c];
            ev.tmr8_uf   = tmr8_uf_i[c];
            ev.t16a_cmpb = t16a_cmpb_i[c];
            ev.t16a_cmpa = t16a_cmpa_i[c];
            ev.t16b_cmpb = t16b_cmpb_i[c];
            ev.t16b_cmpa = t16b_cmpa_i[c];
            ev.rx_full   = rx_full_i[c];
            ev.tx_empty  = tx_empty_i[c];
            ev.adc_done  = adc_done_i[c];
        end

        dtsel_chan u_chan (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .sel_i     (sel[c]),
            .ev_i      (ev),
            .sw_trig_i (sw_trig[c]),
            .clr_i     (clr[c]),
            .start_i   (xfer_start_i[c]),
            .pend_o    (pend[c])
        );
    end

    assign dma_req_o = pend;

    // R1: nothing requests on the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (dma_req_o == '0));
endmodule

// File: tb/dtsel_top_bench.sv
module dtsel_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;

    typedef struct packed {
        logic [1:0] ch;
        logic [3:0] code;
        logic [3:0] src;
        logic       exp;
    } vec_t;

    // R5 / R11: selected strobe sets the request, an unselected one does not
    localparam vec_t VEC [12] = '{
        '{2'd0, 4'd5,  4'd5,  1'b1}, '{2'd1, 4'd6,  4'd6,  1'b1},
        '{2'd2, 4'd7,  4'd7,  1'b1}, '{2'd3, 4'd8,  4'd8,  1'b1},
        '{2'd0, 4'd9,  4'd9,  1'b1}, '{2'd1, 4'd10, 4'd10, 1'b1},
        '{2'd2, 4'd11, 4'd11, 1'b1}, '{2'd3, 4'd12, 4'd12, 1'b1},
        '{2'd0, 4'd5,  4'd6,  1'b0}, '{2'd1, 4'd12, 4'd11, 1'b0},
        '{2'd2, 4'd7,  4'd12, 1'b0}, '{2'd3, 4'd9,  4'd8,  1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_rdata;
    logic [NCH-1:0] pin = '0, port_a = '0, port_b = '0;
    logic [NCH-1:0] tmr8 = '0, ta_b = '0, ta_a = '0, tb_b = '0, tb_a = '0;
    logic [NCH-1:0] rxf = '0, txe = '0, adc = '0, xstart = '0;
    logic [NCH-1:0] req;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtsel_top u_dtsel_top (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_wr_i(bus_wr),
        .bus_rdata_o(bus_rdata),
        .pin_i(pin), .port_a_i(port_a), .port_b_i(port_b),
        .tmr8_uf_i(tmr8), .t16a_cmpb_i(ta_b), .t16a_cmpa_i(ta_a),
        .t16b_cmpb_i(tb_b), .t16b_cmpa_i(tb_a),
        .rx_full_i(rxf), .tx_empty_i(txe), .adc_done_i(adc),
        .xfer_start_i(xstart), .dma_req_o(req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_src(input int ch, input int src, input logic v);
        case (src)
            5:  tmr8[ch] = v;
            6:  ta_b[ch] = v;
            7:  ta_a[ch] = v;
            8:  tb_b[ch] = v;
            9:  tb_a[ch] = v;
            10: rxf[ch]  = v;
            11: txe[ch]  = v;
            12: adc[ch]  = v;
            default: ;
        endcase
    endtask

    task automatic pulse(input int ch, input int src);
        set_src(ch, src, 1'b1);
        @(negedge clk);
        set_src(ch, src, 1'b0);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 req", 32'(req), 0);
        rd(2'd0, d); chk("R1 sel01", 32'(d), 0);
        rd(2'd1, d); chk("R1 sel23", 32'(d), 0);
        rd(2'd3, d); chk("R1 pend", 32'(d), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req after release", 32'(req), 0);

        // R2: packing and readback
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
        rd(2'd0, d); chk("R2 sel01", 32'(d), 32'hA5);
        rd(2'd1, d); chk("R2 sel23", 32'(d), 32'h3C);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);

        // R5 / R11: vector table
        foreach (VEC[i]) begin
            int ch;
            int sh;
            ch = int'(VEC[i].ch);
            sh = 4 * (ch % 2);
            wr(2'(ch / 2), 8'(VEC[i].code) << sh);
            pulse(ch, int'(VEC[i].src));
            chk(VEC[i].exp ? "R5 selected source" : "R11 unselected source",
                32'(req), 32'(VEC[i].exp) << ch);
            wr(2'd3, 8'h0F);
            wr(2'(ch / 2), 8'h00);
        end

        // R3: software strobe with code 0000
        wr(2'd2, 8'h05);
        chk("R3 sw strobe", 32'(req), 32'h5);
        rd(2'd2, d); chk("R3 sw read zero", 32'(d), 0);
        wr(2'd3, 8'h0F);
        wr(2'd2, 8'h00);
        chk("R3 sw write zero", 32'(req), 0);

        // R4: strobe ignored on a channel with a hardware code
        wr(2'd0, 8'h50);
        wr(2'd2, 8'h0F);
        chk("R4 sw ignored ch1", 32'(req), 32'hD);
        wr(2'd3, 8'h0F);

        // R6: pin rise on ch0 (code 0010), timing
        wr(2'd0, 8'h02);
        pin[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 rise not early", 32'(req), 0);
        @(negedge clk);
        chk("R6 rise third edge", 32'(req), 32'h1);
        wr(2'd3, 8'h0F);
        // R6: pin fall on ch0 (code 0001)
        wr(2'd0, 8'h01);
        chk("R6 fall no false", 32'(req), 0);
        pin[0] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 fall not early", 32'(req), 0);
        @(negedge clk);
        chk("R6 fall third edge", 32'(req), 32'h1);
        wr(2'd3, 8'h0F);
        wr(2'd0, 8'h00);
        // R6: port A rise on ch2 (code 0011), port B rise on ch3 (code 0100)
        wr(2'd1, 8'h43);
        port_a[2] = 1'b1; port_b[3] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 port a/b", 32'(req), 32'hC);
        wr(2'd3, 8'h0F);
        wr(2'd1, 8'h00);
        port_a[2] = 1'b0; port_b[3] = 1'b0;
        repeat (3) @(negedge clk);

        // R7: reserved codes on ch3
        for (int code = 13; code < 16; code++) begin
            wr(2'd1, 8'(code) << 4);
            for (int s = 5; s < 13; s++) set_src(3, s, 1'b1);
            port_a[3] = 1'b1; port_b[3] = 1'b1; pin[3] = 1'b1;
            @(negedge clk);
            for (int s = 5; s < 13; s++) set_src(3, s, 1'b0);
            wr(2'd2, 8'h08);
            port_a[3] = 1'b0; port_b[3] = 1'b0; pin[3] = 1'b0;
            repeat (4) @(negedge clk);
            chk("R7 reserved code", 32'(req), 0);
        end
        wr(2'd1, 8'h00);

        // R9: clear by write-one, write-zero ignored, readback
        wr(2'd2, 8'h01);
        wr(2'd3, 8'h00);
        chk("R9 write zero keeps", 32'(req), 32'h1);
        rd(2'd3, d); chk("R9 pend readback", 32'(d), 32'h1);
        wr(2'd3, 8'h01);
        chk("R9 write one clears", 32'(req), 0);

        // R8: transfer start clears
        wr(2'd2, 8'h04);
        xstart[2] = 1'b1; @(negedge clk); xstart[2] = 1'b0;
        chk("R8 start clears", 32'(req), 0);

        // R10: event coincides with clear write, then with transfer start
        wr(2'd0, 8'h50);
        pulse(1, 5);
        chk("R10 pre", 32'(req), 32'h2);
        tmr8[1] = 1'b1;
        wr(2'd3, 8'h02);
        tmr8[1] = 1'b0;
        chk("R10 set beats clear write", 32'(req), 32'h2);
        tmr8[1] = 1'b1; xstart[1] = 1'b1;
        @(negedge clk);
        tmr8[1] = 1'b0; xstart[1] = 1'b0;
        chk("R10 set beats start", 32'(req), 32'h2);
        xstart[1] = 1'b1; @(negedge clk); xstart[1] = 1'b0;
        chk("R8 start alone clears", 32'(req), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule